// File: doc/BRIEF.md
# Masked Vector Element Multiplier

This block multiplies two packed 128-bit vector operands element by element and keeps only the low element-width bits of each product. The element width is chosen per operation: 8, 16, 32 or 64 bits, which gives 16, 8, 4 or 2 elements. The low half of a product does not depend on whether the operands are signed, so one multiplier path handles both kinds of operand. An overflowing product is cut to the element width and raises no flag.

Each element of the result comes from one of three sources. An active element takes its product. An inactive element inside the vector length follows the inactive-element policy. An element at or beyond the vector length follows the tail policy. A policy bit of 0 keeps the old destination value and a policy bit of 1 writes all ones. Operations enter on a valid/ready input stream and leave on a valid/ready output stream through two register stages.

Back-pressure works as follows. When `out_valid` is high and `out_ready` is low, the whole pipe freezes. `out_vd` stays stable and `in_ready` drops, so an upstream producer must hold its operation until `in_ready` returns. With `out_ready` held high the block accepts one operation per cycle.

Top module: `vmul_vv_unit`

## Requirements
- R1: Element i of `out_vd`, at bits [i*W +: W] where W is the element width, equals (element i of `in_vs2` × element i of `in_vs1`) mod 2^W when the element is active. `in_sew` selects W: 2'b00=8, 2'b01=16, 2'b10=32, 2'b11=64.
- R2: Signed operands need no separate control. For example, 8-bit 0xFD × 0x05 gives 0xF1, which is −15 in two's complement.
- R3: An overflowing product is truncated with no other effect. For example, 8-bit 0xFF × 0xFF gives 0x01.
- R4: With `in_vm`=1, every element below the vector length is active. With `in_vm`=0, element i is active only when `in_mask[i]` is 1.
- R5: An inactive element below the vector length keeps its `in_old` value when `in_ma`=0 and becomes all ones when `in_ma`=1.
- R6: An element at index ≥ `in_vl` keeps its `in_old` value when `in_ta`=0 and becomes all ones when `in_ta`=1.
- R7: When `in_vl`=0, every element follows the tail policy.
- R8: When `in_vl` exceeds the element count, it acts as the element count: no element is tail.
- R9: An operation accepted on one clock edge appears with `out_valid`=1 after the next edge, provided `out_ready` is high. It is not visible before that edge.
- R10: While `out_valid`=1 and `out_ready`=0, `out_vd` stays stable, `out_valid` stays high and `in_ready` is low.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block accepts the offered operation |
| in_vs2 | input | 128 | First source vector |
| in_vs1 | input | 128 | Second source vector |
| in_mask | input | 16 | Per-element mask, bit i for element i |
| in_old | input | 128 | Previous destination contents |
| in_sew | input | 2 | Element width code |
| in_vl | input | 8 | Vector length in elements |
| in_vm | input | 1 | 1 = unmasked, 0 = use in_mask |
| in_ma | input | 1 | Inactive-element policy, 1 = write all ones |
| in_ta | input | 1 | Tail policy, 1 = write all ones |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_vd | output | 128 | New destination vector |

## Verification
The bench runs every element width against vector lengths 0 to 17, with both mask modes and all four policy pairs, and checks each element separately. Several classes of fault show up in this sweep:
- An off-by-one vector-length compare would swap one element between body and tail.
- Swapped policy bits would write ones into the wrong class of element.
- A missing clamp would make vector lengths of 16 and 17 misbehave at narrow widths.
- Mixed-up lane slicing would corrupt the products only at the wider widths.

Directed all-ones and negative operands catch a product that is widened or sign-handled instead of truncated. A stalled output checks that the result and `in_ready` stay frozen rather than being overwritten by the next operation.

// File: rtl/vmul_pkg.sv
`timescale 1ns/1ps
package vmul_pkg;
  typedef enum logic [1:0] {
    SEW_B8  = 2'b00,
    SEW_B16 = 2'b01,
    SEW_B32 = 2'b10,
    SEW_B64 = 2'b11
  } sew_e;

  // per-byte source select after policy resolution
  typedef enum logic [1:0] {
    PICK_PROD = 2'b00,
    PICK_OLD  = 2'b01,
    PICK_ONES = 2'b10
  } pick_e;
endpackage

// File: rtl/vmul_lane_mult.sv
`timescale 1ns/1ps
module vmul_lane_mult
  import vmul_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0] a,
  input  logic [VLEN-1:0] b,
  input  sew_e            sew,
  output logic [VLEN-1:0] prod
);
  localparam int NWIDTH = 4;

  logic [NWIDTH-1:0][VLEN-1:0] prod_by_w;

  for (genvar w = 0; w < NWIDTH; w++) begin : g_width
    localparam int W = 8 << w;
    localparam int N = VLEN / W;
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic [W-1:0] lo;
      // W-bit context: the product is kept to its low W bits
      assign lo = a[l*W +: W] * b[l*W +: W];
      assign prod_by_w[w][l*W +: W] = lo;
    end
  end

  assign prod = prod_by_w[sew];
endmodule

// File: rtl/vmul_elem_ctrl.sv
`timescale 1ns/1ps
module vmul_elem_ctrl
  import vmul_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int VL_W = 8,
  localparam int NB  = VLEN / 8,
  localparam int IDX_W = $clog2(NB)
) (
  input  sew_e              sew,
  input  logic [VL_W-1:0]   vl,
  input  logic              vm,
  input  logic [NB-1:0]     mask,
  input  logic              ma,
  input  logic              ta,
  output pick_e [NB-1:0]    pick
);
  always_comb begin
    for (int j = 0; j < NB; j++) begin
      logic [IDX_W-1:0] idx;
      logic body;
      logic act;
      idx  = IDX_W'(j) >> sew;
      // idx never reaches the element count, so a large vl clamps itself
      body = VL_W'(idx) < vl;
      act  = body && (vm || mask[idx]);
      if (act)       pick[j] = PICK_PROD;
      else if (body) pick[j] = ma ? PICK_ONES : PICK_OLD;
      else           pick[j] = ta ? PICK_ONES : PICK_OLD;
    end
  end
endmodule

// File: rtl/vmul_merge.sv
`timescale 1ns/1ps
module vmul_merge
  import vmul_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NB  = VLEN / 8
) (
  input  logic [VLEN-1:0] prod,
  input  logic [VLEN-1:0] old,
  input  pick_e [NB-1:0]  pick,
  output logic [VLEN-1:0] res
);
  always_comb begin
    for (int j = 0; j < NB; j++) begin
      unique case (pick[j])
        PICK_PROD: res[j*8 +: 8] = prod[j*8 +: 8];
        PICK_OLD:  res[j*8 +: 8] = old[j*8 +: 8];
        default:   res[j*8 +: 8] = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/vmul_vv_unit.sv
`timescale 1ns/1ps
module vmul_vv_unit
  import vmul_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int VL_W = 8,
  localparam int NB  = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] in_vs2,
  input  logic [VLEN-1:0] in_vs1,
  input  logic [NB-1:0]   in_mask,
  input  logic [VLEN-1:0] in_old,
  input  logic [1:0]      in_sew,
  input  logic [VL_W-1:0] in_vl,
  input  logic            in_vm,
  input  logic            in_ma,
  input  logic            in_ta,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_vd
);
  logic            adv;
  logic [VLEN-1:0] prod_c;
  pick_e [NB-1:0]  pick_c;

  logic            s1_valid;
  logic [VLEN-1:0] s1_prod;
  logic [VLEN-1:0] s1_old;
  pick_e [NB-1:0]  s1_pick;
  logic [VLEN-1:0] res_c;

  logic            s2_valid;
  logic [VLEN-1:0] s2_vd;

  // whole pipe moves unless a result is held by the consumer
  assign adv      = !s2_valid || out_ready;
  assign in_ready = adv;

  vmul_lane_mult #(.VLEN(VLEN)) u_mult (
    .a    (in_vs2),
    .b    (in_vs1),
    .sew  (sew_e'(in_sew)),
    .prod (prod_c)
  );

  vmul_elem_ctrl #(.VLEN(VLEN), .VL_W(VL_W)) u_ctrl (
    .sew  (sew_e'(in_sew)),
    .vl   (in_vl),
    .vm   (in_vm),
    .mask (in_mask),
    .ma   (in_ma),
    .ta   (in_ta),
    .pick (pick_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_old   <= '0;
      s1_pick  <= {NB{PICK_OLD}};
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod <= prod_c;
        s1_old  <= in_old;
        s1_pick <= pick_c;
      end
    end
  end

  vmul_merge #(.VLEN(VLEN)) u_merge (
    .prod (s1_prod),
    .old  (s1_old),
    .pick (s1_pick),
    .res  (res_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_vd    <= '0;
    end else if (adv) begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_vd <= res_c;
    end
  end

  assign out_valid = s2_valid;
  assign out_vd    = s2_vd;
endmodule

// File: rtl/vmul_vv_checker.sv
`timescale 1ns/1ps
module vmul_vv_checker #(
  parameter int VLEN = 128,
  parameter int VL_W = 8,
  localparam int NB  = VLEN / 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VLEN-1:0] in_vs2,
  input logic [VLEN-1:0] in_vs1,
  input logic [NB-1:0]   in_mask,
  input logic [VLEN-1:0] in_old,
  input logic [1:0]      in_sew,
  input logic [VL_W-1:0] in_vl,
  input logic            in_vm,
  input logic            in_ma,
  input logic            in_ta,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] out_vd
);
  // shadow of operation attributes, stepped with the pipe
  logic            c1_none, c2_none, c1_vl0, c2_vl0;
  logic            c1_ma, c2_ma, c1_ta, c2_ta;
  logic [VLEN-1:0] c1_old, c2_old;
  logic            no_act;

  assign no_act = (in_vl == '0) || (!in_vm && in_mask == '0);

  always_ff @(posedge clk) begin
    if (in_ready) begin
      c1_none <= no_act;       c2_none <= c1_none;
      c1_vl0  <= in_vl == '0;  c2_vl0  <= c1_vl0;
      c1_ma   <= in_ma;        c2_ma   <= c1_ma;
      c1_ta   <= in_ta;        c2_ta   <= c1_ta;
      c1_old  <= in_old;       c2_old  <= c1_old;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready)); // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vd))); // R10

  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid); // R9

  AST_NONE_ACTIVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c2_none && !c2_ma && !c2_ta) |-> (out_vd == c2_old)); // R5

  AST_VL0_TAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c2_vl0 && c2_ta) |-> (out_vd == '1)); // R7

  AST_VL0_TAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c2_vl0 && !c2_ta) |-> (out_vd == c2_old)); // R6
endmodule

bind vmul_vv_unit vmul_vv_checker #(.VLEN(VLEN), .VL_W(VL_W)) u_chk (.*);

// File: tb/tb_vmul_vv_unit.sv
`timescale 1ns/1ps
module tb_vmul_vv_unit;
  localparam int VLEN = 128;
  localparam int VL_W = 8;
  localparam int NB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [VLEN-1:0] in_vs2 = '0, in_vs1 = '0, in_old = '0;
  logic [NB-1:0]   in_mask = '0;
  logic [1:0]      in_sew = '0;
  logic [VL_W-1:0] in_vl = '0;
  logic            in_vm = 1'b0, in_ma = 1'b0, in_ta = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [VLEN-1:0] out_vd;

  int checks = 0;
  int errors = 0;
  logic [VLEN-1:0] got_vd;

  always #10 clk = ~clk;

  vmul_vv_unit #(.VLEN(VLEN), .VL_W(VL_W)) dut (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                         input logic [NB-1:0] m, input logic [VLEN-1:0] old,
                         input logic [1:0] sew, input int vl,
                         input logic vm, input logic ma, input logic ta);
    int W = 8 << sew;
    int n = VLEN / W;
    logic [63:0] emask = (W == 64) ? '1 : ((64'd1 << W) - 64'd1);
    @(negedge clk);
    in_vs2 = a; in_vs1 = b; in_mask = m; in_old = old; in_sew = sew;
    in_vl = VL_W'(vl); in_vm = vm; in_ma = ma; in_ta = ta; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 not before second edge", 128'(out_valid), 128'd0);
    @(negedge clk);
    check("R9 valid after second edge", 128'(out_valid), 128'd1);
    got_vd = out_vd;
    for (int e = 0; e < n; e++) begin
      logic [63:0] ea = 64'(a >> (e*W)) & emask;
      logic [63:0] eb = 64'(b >> (e*W)) & emask;
      logic [63:0] eo = 64'(old >> (e*W)) & emask;
      logic [63:0] gv = 64'(got_vd >> (e*W)) & emask;
      logic [63:0] ex;
      logic [63:0] pr = ea * eb;
      logic body = e < vl;
      logic actv = body && (vm || m[e]);
      string tag;
      if (actv)      ex = pr & emask;
      else if (body) ex = ma ? emask : eo;
      else           ex = ta ? emask : eo;
      if (vl > n)         tag = "R8";
      else if (actv)      tag = vm ? "R4" : "R1";
      else if (body)      tag = "R5";
      else if (vl == 0)   tag = "R7";
      else                tag = "R6";
      check(tag, 128'(gv), 128'(ex));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 out_valid reset", 128'(out_valid), 128'd0);
    check("R11 in_ready reset", 128'(in_ready), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after release", 128'(out_valid), 128'd0);

    // sweep: every width, vl 0..17, both mask modes, all policy pairs
    for (int s = 0; s < 4; s++)
      for (int vl = 0; vl < 18; vl++)
        for (int p = 0; p < 8; p++)
          run_txn({$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  NB'($urandom),
                  {$urandom, $urandom, $urandom, $urandom},
                  2'(s), vl, p[0], p[1], p[2]);

    // R3: overflow truncation, 0xFF*0xFF -> 0x01 in every byte
    run_txn({VLEN{1'b1}}, {VLEN{1'b1}}, '0, '0, 2'b00, 16, 1'b1, 1'b0, 1'b0);
    check("R3 overflow truncated", got_vd, {NB{8'h01}});
    // R2: signed operands, 0xFD*0x05 -> 0xF1
    run_txn({NB{8'hFD}}, {NB{8'h05}}, '0, '0, 2'b00, 16, 1'b1, 1'b0, 1'b0);
    check("R2 signed low half", got_vd, {NB{8'hF1}});
    // R2 at 64 bits: -1 * 7 -> -7
    run_txn({2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'd7}}, '0, '0, 2'b11, 2, 1'b1, 1'b0, 1'b0);
    check("R2 signed 64-bit", got_vd, {2{64'hFFFF_FFFF_FFFF_FFF9}});

    // R10: back-pressure holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_vs2 = {NB{8'h03}}; in_vs1 = {NB{8'h04}}; in_sew = 2'b00; in_vl = 8'd16;
    in_vm = 1'b1; in_ma = 1'b0; in_ta = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 result present", 128'(out_valid), 128'd1);
    got_vd = out_vd;
    repeat (3) @(negedge clk);
    check("R10 valid held", 128'(out_valid), 128'd1);
    check("R10 data stable", out_vd, got_vd);
    check("R10 data value", out_vd, {NB{8'h0C}});
    check("R10 in_ready low", 128'(in_ready), 128'd0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", 128'(out_valid), 128'd0);
    check("R10 in_ready back", 128'(in_ready), 128'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule